// File: doc/BRIEF.md
# Glitch-Free Selectable Clock Divider

This block turns a reference clock into an output clock that runs at the reference rate, or at one half, one quarter or one eighth of it. Two select pins pick the rate and may be changed at any moment while the output is toggling. The block applies a new rate only at the end of a complete output period, so the output never shows a runt pulse and never cuts a high or low phase short.

A run-enable input, driven by an external power-up sequencer, decides whether the clock reaches the output at all. While run-enable is low, the output rests low. Starting and stopping also take effect only at a period boundary, so the first and the last pulse each have their full width. The select pins and run-enable are asynchronous to the reference clock and pass through a two-flop synchronizer before they are used. The divided rates come from registers and have an exact 50% duty cycle. At the undivided rate the output is the reference clock gated by a flop clocked on the falling edge, so its duty cycle is that of the reference.

Top module: `clkdiv_glitchfree`

## Requirements
- R1: The pin pair {rate_sel_a_i, rate_sel_b_i} selects the ratio: 2'b00 gives divide-by-8, 2'b01 gives divide-by-4, 2'b11 gives divide-by-2 and 2'b10 gives the undivided reference.
- R2: Select pins and run_en_i pass through a two-flop synchronizer in the reference domain, and a new steady setting reaches the output within a few output periods.
- R3: A rate change, start or stop takes effect only after the current output period has ended, so every high phase of clk_o lasts exactly the high time of one of the four rates (0.5, 1, 2 or 4 reference periods).
- R4: No high or low phase of clk_o is shorter than 45% of one reference period, across any sequence of select and enable changes.
- R5: At a divided rate of 2^k, clk_o has a steady period of 2^k reference periods and is high for exactly half of it.
- R6: At the undivided rate, clk_o follows the reference clock: it is high for its high phase and low for its low phase.
- R7: While run_en_i is low, clk_o stays low with no edges. Raising run_en_i starts the clock with a full-width first pulse.
- R8: While rst_n is low, clk_o is low. Reset clears the phase counter, stops the output and selects divide-by-8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel_a_i | input | 1 | Rate select, upper bit (asynchronous) |
| rate_sel_b_i | input | 1 | Rate select, lower bit (asynchronous) |
| run_en_i | input | 1 | Lets the clock run when high (asynchronous) |
| clk_o | output | 1 | Divided or gated output clock |

## Verification
The bench builds the block with its default values: a two-bit rate code, which gives a three-bit phase counter, and a two-stage synchronizer. This configuration is small enough to test every ordered pair of the four rates as a switch, so each switchover path, including the paths into and out of the undivided mode, gets its steady period and duty measured. A time-based monitor also measures every high and low phase through a long run of random select and enable changes.

// File: rtl/clkdiv_pkg.sv
// Shared widths, types and helper functions for the selectable clock divider.
// Assumes the division ratio is a power of two, 2^rate, with rate in 0..MAX_RATE.
package clkdiv_pkg;
    localparam int RATE_W   = 2;                  // width of the log2 ratio
    localparam int MAX_RATE = (1 << RATE_W) - 1;  // largest log2 ratio
    localparam int PH_W     = MAX_RATE;           // phase counter spans 2^MAX_RATE

    typedef logic [RATE_W-1:0] rate_t;
    typedef logic [PH_W-1:0]   phase_t;

    // Map the two select pins to log2 of the division ratio.
    function automatic rate_t decode_sel(input logic sel_a, input logic sel_b);
        rate_t r;
        unique case ({sel_a, sel_b})
            2'b00:   r = rate_t'(3);
            2'b01:   r = rate_t'(2);
            2'b11:   r = rate_t'(1);
            default: r = rate_t'(0);
        endcase
        return r;
    endfunction

    // Index of the final reference cycle of one output period.
    function automatic phase_t last_phase(input rate_t r);
        logic [PH_W:0] span;
        span = (PH_W+1)'(1) << r;
        return phase_t'(span - 1'b1);
    endfunction

    // Number of reference cycles that the divided output stays high.
    function automatic phase_t half_span(input rate_t r);
        phase_t h;
        if (r == rate_t'(0)) h = '0;
        else                 h = phase_t'(1) << (r - rate_t'(1));
        return h;
    endfunction
endpackage

// File: rtl/clkdiv_sync.sv
// Multi-stage synchronizer for a vector of slow, independent control bits.
// Assumes each bit is quasi-static; bits may land one cycle apart, which the
// downstream boundary logic tolerates because it samples only at period ends.
module clkdiv_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the asynchronous inputs.
                always_ff @(posedge clk_i) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_i;
                end
            end else begin : g_next
                // Later stages let metastability settle.
                always_ff @(posedge clk_i) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/clkdiv_seq.sv
// Period sequencer: tracks the active ratio, run state and phase inside the
// current output period, and registers the divided clock level.
// Assumes requested settings are already synchronous; they are adopted only at
// a period boundary (end of a low phase, every cycle at rate 0, or when idle).
module clkdiv_seq
    import clkdiv_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_n,
    input  rate_t  req_rate_i,
    input  logic   req_run_i,
    output rate_t  rate_q_o,
    output logic   run_q_o,
    output phase_t ph_q_o,
    output logic   div_q_o,
    output logic   full_run_o
);
    rate_t  rate_q, rate_d;
    logic   run_q, run_d;
    phase_t ph_q, ph_d;
    logic   div_q, div_d;
    logic   boundary;

    // Decide whether the current period ends here and compute the next state.
    always_comb begin
        boundary = !run_q || (rate_q == rate_t'(0)) || (ph_q == last_phase(rate_q));
        if (boundary) begin
            rate_d = req_rate_i;
            run_d  = req_run_i;
            ph_d   = '0;
        end else begin
            rate_d = rate_q;
            run_d  = run_q;
            ph_d   = ph_q + phase_t'(1);
        end
        div_d = run_d && (rate_d != rate_t'(0)) && (ph_d < half_span(rate_d));
    end

    // Register the sequencer state; reset selects divide-by-8 and stops.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            rate_q <= rate_t'(MAX_RATE);
            run_q  <= 1'b0;
            ph_q   <= '0;
            div_q  <= 1'b0;
        end else begin
            rate_q <= rate_d;
            run_q  <= run_d;
            ph_q   <= ph_d;
            div_q  <= div_d;
        end
    end

    assign rate_q_o   = rate_q;
    assign run_q_o    = run_q;
    assign ph_q_o     = ph_q;
    assign div_q_o    = div_q;
    assign full_run_o = run_q && (rate_q == rate_t'(0));
endmodule

// File: rtl/clkdiv_outgate.sv
// Output stage: gates the reference clock for the undivided rate with a
// falling-edge enable flop, and merges it with the registered divided level.
// Assumes div_q_i changes only on rising reference edges and is low whenever
// full_run_i is high outside a handover cycle.
module clkdiv_outgate (
    input  logic clk_i,
    input  logic rst_n,
    input  logic full_run_i,
    input  logic div_q_i,
    output logic gate_q_o,
    output logic clk_o
);
    logic gate_q;

    // Change the pass-through enable only while the reference is low.
    always_ff @(negedge clk_i) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= full_run_i;
    end

    assign gate_q_o = gate_q;
    assign clk_o    = (clk_i & gate_q) | div_q_i;
endmodule

// File: rtl/clkdiv_glitchfree.sv
// Top level of the glitch-free selectable clock divider.
// Synchronizes the select and enable pins, decodes the ratio, sequences
// period-aligned switchovers and drives the output clock.
// Assumes a single free-running reference clock and a synchronous reset.
module clkdiv_glitchfree
    import clkdiv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic rate_sel_a_i,
    input  logic rate_sel_b_i,
    input  logic run_en_i,
    output logic clk_o
);
    localparam int CTRL_W = 3;

    logic [CTRL_W-1:0] ctrl_s;
    rate_t             req_rate;
    rate_t             cur_rate;
    logic              cur_run;
    phase_t            cur_ph;
    logic              div_q;
    logic              full_run;
    logic              gate_q;

    clkdiv_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_n   (rst_n),
        .async_i ({run_en_i, rate_sel_a_i, rate_sel_b_i}),
        .sync_o  (ctrl_s)
    );

    // Turn the synchronized select pins into log2 of the ratio.
    always_comb req_rate = decode_sel(ctrl_s[1], ctrl_s[0]);

    clkdiv_seq u_seq (
        .clk_i      (clk_i),
        .rst_n      (rst_n),
        .req_rate_i (req_rate),
        .req_run_i  (ctrl_s[2]),
        .rate_q_o   (cur_rate),
        .run_q_o    (cur_run),
        .ph_q_o     (cur_ph),
        .div_q_o    (div_q),
        .full_run_o (full_run)
    );

    clkdiv_outgate u_gate (
        .clk_i      (clk_i),
        .rst_n      (rst_n),
        .full_run_i (full_run),
        .div_q_i    (div_q),
        .gate_q_o   (gate_q),
        .clk_o      (clk_o)
    );
endmodule

// File: rtl/clkdiv_glitchfree_chk.sv
// Assertion checker for the clock divider, bound to the top module.
// Observes sequencer state and the output gate from the reference clock.
module clkdiv_glitchfree_chk
    import clkdiv_pkg::*;
(
    input logic   clk_i,
    input logic   rst_n,
    input rate_t  cur_rate,
    input logic   cur_run,
    input phase_t cur_ph,
    input logic   div_q,
    input logic   gate_q
);
    logic [PH_W:0] high_cnt;

    // Count consecutive sampled high cycles of the divided level.
    always_ff @(posedge clk_i) begin
        if (!rst_n)     high_cnt <= '0;
        else if (div_q) high_cnt <= high_cnt + 1'b1;
        else            high_cnt <= '0;
    end

    // R3: the ratio only changes after a sampled low output level.
    a_r3_switch_after_low: assert property (@(posedge clk_i) disable iff (!rst_n)
        (cur_rate != $past(cur_rate)) |-> !$past(div_q));

    // R5: a divided high phase starts at phase zero of a running divided period.
    a_r5_rise_at_phase0: assert property (@(posedge clk_i) disable iff (!rst_n)
        $rose(div_q) |-> (cur_ph == '0) && cur_run && (cur_rate != rate_t'(0)));

    // R5: each divided high phase lasts exactly half the period.
    a_r5_high_len: assert property (@(posedge clk_i) disable iff (!rst_n)
        $fell(div_q) |-> (high_cnt == (PH_W+1)'(half_span(cur_rate))));

    // R7: nothing drives the output once the sequencer has stopped for a cycle.
    a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_n)
        (!cur_run && !$past(cur_run)) |-> (!div_q && !gate_q));
endmodule

bind clkdiv_glitchfree clkdiv_glitchfree_chk u_chk (
    .clk_i    (clk_i),
    .rst_n    (rst_n),
    .cur_rate (cur_rate),
    .cur_run  (cur_run),
    .cur_ph   (cur_ph),
    .div_q    (div_q),
    .gate_q   (gate_q)
);

// File: tb/clkdiv_glitchfree_tb_top.sv
`timescale 1ns/1ps
module clkdiv_glitchfree_tb_top;
    localparam real TCLK = 20.0;

    logic clk_i = 1'b0;
    logic rst_n = 1'b0;
    logic sel_a = 1'b0;
    logic sel_b = 1'b0;
    logic run_en = 1'b0;
    logic clk_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    bit  mon_on = 1'b0;
    bit  have_last = 1'b0;
    real last_t = 0.0;
    int  edge_cnt = 0;

    always #10 clk_i = ~clk_i;

    clkdiv_glitchfree dut_i (
        .clk_i        (clk_i),
        .rst_n        (rst_n),
        .rate_sel_a_i (sel_a),
        .rate_sel_b_i (sel_b),
        .run_en_i     (run_en),
        .clk_o        (clk_o)
    );

    task automatic check(input bit ok, input string req, input real act, input real exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0.2f expected=%0.2f at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit near(input real a, input real b);
        return (a - b < 0.5) && (b - a < 0.5);
    endfunction

    // Log2 of the ratio for a select code, per the encoding in R1.
    function automatic int code_rate(input int code);
        case (code)
            0: return 3;
            1: return 2;
            3: return 1;
            default: return 0;
        endcase
    endfunction

    // Phase monitor, R3 and R4: every phase is long enough, every high is a legal width.
    always @(clk_o) begin
        real now, dur;
        now = $realtime;
        edge_cnt++;
        if (mon_on && have_last) begin
            dur = now - last_t;
            check(dur > 0.45 * TCLK - 0.01, "R4 min phase", dur, 0.45 * TCLK);
            if (clk_o == 1'b0)
                check(near(dur, 10.0) || near(dur, 20.0) || near(dur, 40.0) || near(dur, 80.0),
                      "R3 high width", dur, 10.0);
        end
        last_t = now;
        have_last = mon_on;
    end

    task automatic set_code(input int code);
        @(negedge clk_i);
        sel_a = code[1];
        sel_b = code[0];
    endtask

    // R5 / R6: measure one steady period and its high time.
    task automatic measure(input int code, input string req);
        real t0, t1, t2, per, hi;
        int  k;
        k = code_rate(code);
        repeat (30) @(posedge clk_i);
        @(posedge clk_o); t0 = $realtime;
        @(negedge clk_o); t1 = $realtime;
        @(posedge clk_o); t2 = $realtime;
        per = t2 - t0;
        hi  = t1 - t0;
        check(near(per, TCLK * (1 << k)), {req, " period"}, per, TCLK * (1 << k));
        check(near(hi, 0.5 * TCLK * (1 << k)), {req, " high"}, hi, 0.5 * TCLK * (1 << k));
    endtask

    initial begin
        // R8: output low while reset is held, even with a full-rate request.
        sel_a = 1'b1; sel_b = 1'b0; run_en = 1'b1;
        repeat (6) @(posedge clk_i);
        #5 check(clk_o == 1'b0, "R8 low in reset (clk high)", clk_o, 0);
        @(negedge clk_i); #5 check(clk_o == 1'b0, "R8 low in reset (clk low)", clk_o, 0);
        sel_a = 1'b0; sel_b = 1'b0;
        @(negedge clk_i); rst_n = 1'b1;
        mon_on = 1'b1;
        measure(0, "R8 R1 div8 after reset");

        // R1 R2 R5 R6: every ordered pair of rates as a switch.
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                set_code(a); measure(a, code_rate(a) == 0 ? "R6 R1 from" : "R5 R1 from");
                set_code(b); measure(b, code_rate(b) == 0 ? "R6 R2 to" : "R5 R2 to");
            end
        end

        // R7: disabled output stays low with no edges, at each rate.
        for (int c = 0; c < 4; c++) begin
            set_code(c);
            repeat (20) @(posedge clk_i);
            @(negedge clk_i); run_en = 1'b0;
            repeat (20) @(posedge clk_i);
            edge_cnt = 0;
            repeat (40) begin
                @(posedge clk_i); #5 check(clk_o == 1'b0, "R7 idle low", clk_o, 0);
            end
            check(edge_cnt == 0, "R7 no edges while disabled", edge_cnt, 0);
            @(negedge clk_i); run_en = 1'b1;
            measure(c, "R7 restart");
        end

        // R3 R4: random select and enable changes with phases watched by the monitor.
        for (int i = 0; i < 400; i++) begin
            int code, gap;
            code = $urandom_range(0, 3);
            gap  = $urandom_range(1, 24);
            @(negedge clk_i);
            sel_a = code[1];
            sel_b = code[0];
            if ($urandom_range(0, 9) == 0) run_en = ~run_en;
            repeat (gap) @(posedge clk_i);
        end
        @(negedge clk_i); run_en = 1'b1;
        set_code(3); measure(3, "R5 after random run");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(TCLK * 150000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule